// File: doc/BRIEF.md
# Status-Register Write Protection Unit

This unit keeps the three-bit protection code of a serial EEPROM status register and decides, for a candidate byte address, whether a write may proceed. A status-write request carries a new code. The code is held as pending while the chip select is low. It is committed when the controller signals that the internal write cycle has begun. A hardware write-protect input (active low) inhibits every array write. If it falls during the selected phase, it also throws away a pending status write. Once the internal cycle has started, it can no longer affect that status write.

The code selects one protected region: nothing, one of four equal quarters, the lower half, the first page or the last page. The array size is set by an address-width parameter. The page size follows from it: 16 bytes for arrays of up to 512 bytes, 32 bytes for larger ones. The region bounds are worked out from these parameters, so one design covers every array size. The serial framing and the memory array are outside this unit. The unit receives decoded strobes and returns a write-allowed flag, a one-cycle abort flag and a one-cycle array-write rejection flag.

Top module: `wp_guard`

## Requirements
- R1: After reset, protBits is 000, statusByte is 0x00, and statAbort and wrReject are low. statusByte always equals {5'b00000, protBits}, so bits 7..3 read 0.
- R2: With wpN high, wrOk is low exactly when wrAddr lies in the region selected by protBits, and high otherwise. For a 256-byte array the regions are: code 000 none; 001 0x00-0x3F; 010 0x40-0x7F; 011 0x80-0xBF; 100 0xC0-0xFF; 101 0x00-0x7F.
- R3: Codes 110 and 111 protect the first page and the last page. A page is 16 bytes when ADDR_W is 9 or less and 32 bytes otherwise, so a 256-byte array gives 0x00-0x0F and 0xF0-0xFF.
- R4: While wpN is low, wrOk is low for every address.
- R5: statWrReq in a cycle with csN low and wpN high captures statWrCode as pending. A later wrStart with a code pending loads that code into protBits at the same clock edge. wrStart with nothing pending leaves protBits unchanged.
- R6: If a code is pending and wpN is low while csN is low, the pending code is dropped and statAbort is high for exactly the next cycle. A later wrStart then leaves protBits unchanged.
- R7: wpN low while csN is high does not drop a pending code. Once a code has been committed, wpN has no effect on protBits.
- R8: If wrStart arrives in the same cycle as the drop condition of R6, the drop wins: protBits stays unchanged and statAbort rises.
- R9: statWrReq is ignored when wpN is low or csN is high. No code becomes pending, and a following wrStart leaves protBits unchanged.
- R10: memWrStart in a cycle where wrOk is low makes wrReject high for the next cycle; otherwise wrReject is low. The regions are page-aligned, so a page write is rejected as a whole when its start address is protected.
- R11: A second captured statWrReq before wrStart replaces the pending code, so the last code written is the one committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| wpN | input | 1 | Hardware write protect, active low |
| statWrReq | input | 1 | Status-write data byte received (one-cycle strobe) |
| statWrCode | input | 3 | Protection code field (bits 2..0) of the status byte |
| wrStart | input | 1 | Internal write cycle has started (one-cycle strobe) |
| memWrStart | input | 1 | Array write about to commit at wrAddr (one-cycle strobe) |
| wrAddr | input | ADDR_W | Candidate byte address |
| protBits | output | 3 | Current protection code |
| statusByte | output | 8 | Status register as read back |
| wrOk | output | 1 | Write to wrAddr is allowed |
| statAbort | output | 1 | A pending status write was cancelled (one cycle) |
| wrReject | output | 1 | An array write was refused (one cycle) |

## Verification
Two functions can meet in the same cycle: the commit of a pending code on wrStart, and its cancellation by wpN low while csN is still low. The bench forces this meeting directly, by raising wrStart with csN and wpN both low, and also reaches it at random. It judges the outcome by the rule that cancellation wins: protBits must keep its old value and statAbort must pulse. The random phase also mixes captures with commits in one cycle, and array writes with code changes, against a bench model of the region bounds.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic capture;  // take statWrCode as pending
    logic cancel;   // drop the pending code
    logic commit;   // move pending code into protBits
  } wpStrobe_t;

  typedef enum logic [2:0] {
    PROT_NONE    = 3'd0,
    PROT_Q1      = 3'd1,
    PROT_Q2      = 3'd2,
    PROT_Q3      = 3'd3,
    PROT_Q4      = 3'd4,
    PROT_HALF    = 3'd5,
    PROT_FIRSTPG = 3'd6,
    PROT_LASTPG  = 3'd7
  } protCode_t;

  // Page address bits: 16-byte pages up to 512 bytes, 32-byte pages beyond.
  function automatic int pageBits(input int addrW);
    return (addrW <= 9) ? 4 : 5;
  endfunction

endpackage

// File: rtl/wp_region_dec.sv
module wp_region_dec
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [2:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              protHit
);

  localparam int PAGE_W = pageBits(ADDR_W);
  localparam int NUM_Q  = 4;

  logic [7:0] hit;

  assign hit[PROT_NONE] = 1'b0;

  // Quarters: the two top address bits name the quarter.
  for (genvar q = 0; q < NUM_Q; q++) begin : g_quarter
    assign hit[q + 1] = (addr[ADDR_W-1 -: 2] == 2'(q));
  end

  assign hit[PROT_HALF]    = ~addr[ADDR_W-1];
  // Page regions: every bit above the in-page offset is zero or one.
  assign hit[PROT_FIRSTPG] = ~|addr[ADDR_W-1:PAGE_W];
  assign hit[PROT_LASTPG]  = &addr[ADDR_W-1:PAGE_W];

  assign protHit = hit[code];

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      wpN,
  input  logic      statWrReq,
  input  logic      wrStart,
  output wpStrobe_t strobe,
  output logic      statAbort
);

  logic pendValid;

  always_comb begin
    strobe.capture = statWrReq & ~csN & wpN;
    strobe.cancel  = pendValid & ~csN & ~wpN;
    strobe.commit  = wrStart & pendValid & ~strobe.cancel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      statAbort <= 1'b0;
    end else begin
      statAbort <= strobe.cancel;
      if (strobe.cancel)       pendValid <= 1'b0;
      else if (strobe.capture) pendValid <= 1'b1;
      else if (strobe.commit)  pendValid <= 1'b0;
    end
  end

  // R6
  cancel_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !csN && !wpN) |=> (!pendValid && statAbort));

  // R9
  wp_no_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pendValid && !wpN) |=> !pendValid);

  // R7
  cs_high_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && csN && !wrStart) |=> pendValid);

  // R6
  abort_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    statAbort |=> !statAbort);

endmodule

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  wpStrobe_t  strobe,
  input  logic [2:0] statWrCode,
  input  logic       memWrStart,
  input  logic       addrOk,
  output logic [2:0] protBits,
  output logic [7:0] statusByte,
  output logic       wrReject
);

  logic [2:0] pendCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCode <= PROT_NONE;
      protBits <= PROT_NONE;
      wrReject <= 1'b0;
    end else begin
      wrReject <= memWrStart & ~addrOk;
      if (strobe.cancel)       pendCode <= PROT_NONE;
      else if (strobe.capture) pendCode <= statWrCode;
      if (strobe.commit)       protBits <= pendCode;
    end
  end

  assign statusByte = {5'b00000, protBits};

  // R5
  commit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (protBits == $past(pendCode)));

  // R8
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(protBits));

  // R10
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrStart && !addrOk) |=> wrReject);

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wpN,
  input  logic              statWrReq,
  input  logic [2:0]        statWrCode,
  input  logic              wrStart,
  input  logic              memWrStart,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic [2:0]        protBits,
  output logic [7:0]        statusByte,
  output logic              wrOk,
  output logic              statAbort,
  output logic              wrReject
);

  wpStrobe_t strobe;
  logic      protHit;

  wp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .wpN       (wpN),
    .statWrReq (statWrReq),
    .wrStart   (wrStart),
    .strobe    (strobe),
    .statAbort (statAbort)
  );

  wp_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .code    (protBits),
    .addr    (wrAddr),
    .protHit (protHit)
  );

  assign wrOk = wpN & ~protHit;

  wp_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .statWrCode (statWrCode),
    .memWrStart (memWrStart),
    .addrOk     (wrOk),
    .protBits   (protBits),
    .statusByte (statusByte),
    .wrReject   (wrReject)
  );

endmodule

// File: tb/wp_guard_test.sv
`timescale 1ns/1ps
module wp_guard_test;

  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wpN = 1'b1, statWrReq = 1'b0, wrStart = 1'b0, memWrStart = 1'b0;
  logic [2:0] statWrCode = 3'd0;
  logic [AW-1:0] wrAddr = '0;
  logic [2:0] protBits;
  logic [7:0] statusByte;
  logic wrOk, statAbort, wrReject;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model
  logic [2:0] ep = 3'd0;
  logic [2:0] epC = 3'd0;
  bit epV = 1'b0;
  bit expAbort = 1'b0;
  bit expRej = 1'b0;

  always #4 clk = ~clk;

  wp_guard #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN), .statWrReq(statWrReq),
    .statWrCode(statWrCode), .wrStart(wrStart), .memWrStart(memWrStart),
    .wrAddr(wrAddr), .protBits(protBits), .statusByte(statusByte),
    .wrOk(wrOk), .statAbort(statAbort), .wrReject(wrReject)
  );

  function automatic bit refProt(input logic [2:0] code, input int addr);
    int size = 1 << AW;
    int qs = size / 4;
    int pg = (AW <= 9) ? 16 : 32;
    case (code)
      3'd1, 3'd2, 3'd3, 3'd4:
        return (addr >= (int'(code) - 1) * qs) && (addr < int'(code) * qs);
      3'd5: return addr < size / 2;
      3'd6: return addr < pg;
      3'd7: return addr >= size - pg;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit cs, input bit wp, input bit req, input logic [2:0] code,
                      input bit st, input bit mst, input int addr,
                      input string tOk, input string tReg);
    bit expOk, canc, cap, com;
    @(negedge clk);
    csN = cs; wpN = wp; statWrReq = req; statWrCode = code;
    wrStart = st; memWrStart = mst; wrAddr = AW'(addr);
    #1;
    expOk = wp && !refProt(ep, addr);
    check(wrOk === expOk, tOk, int'(wrOk), int'(expOk));
    canc = epV && !cs && !wp;
    cap  = req && !cs && wp;
    com  = st && epV && !canc;
    @(posedge clk);
    if (com) ep = epC;
    if (canc) begin epV = 1'b0; epC = 3'd0; end
    else if (cap) begin epV = 1'b1; epC = code; end
    else if (com) epV = 1'b0;
    expAbort = canc;
    expRej = mst && !expOk;
    #1;
    check(protBits === ep, tReg, int'(protBits), int'(ep));
    check(statusByte === {5'b0, ep}, "R1 statusByte", int'(statusByte), int'({5'b0, ep}));
    check(statAbort === expAbort, "R6 statAbort", int'(statAbort), int'(expAbort));
    check(wrReject === expRej, "R10 wrReject", int'(wrReject), int'(expRej));
  endtask

  task automatic idle(input int addr, input string tOk);
    step(1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, addr, tOk, "R5 protBits");
  endtask

  task automatic prog(input logic [2:0] c);
    step(1'b0, 1'b1, 1'b1, c, 1'b0, 1'b0, 0, "R2 wrOk", "R5 protBits");
    step(1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 0, "R2 wrOk", "R5 protBits");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int lo, hi;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(protBits === 3'd0, "R1 reset protBits", int'(protBits), 0);
    check(statusByte === 8'd0, "R1 reset statusByte", int'(statusByte), 0);
    check(statAbort === 1'b0, "R1 reset statAbort", int'(statAbort), 0);
    check(wrReject === 1'b0, "R1 reset wrReject", int'(wrReject), 0);
    check(wrOk === 1'b1, "R1 reset wrOk", int'(wrOk), 1);

    // R2 / R3 every code, boundaries around the region
    for (int c = 1; c < 8; c++) begin
      prog(3'(c));
      lo = 0; hi = 0;
      for (int a = 0; a < (1 << AW); a++) if (refProt(3'(c), a)) begin hi = a; end
      for (int a = (1 << AW) - 1; a >= 0; a--) if (refProt(3'(c), a)) begin lo = a; end
      if (lo > 0) idle(lo - 1, (c >= 6) ? "R3 wrOk" : "R2 wrOk");
      idle(lo, (c >= 6) ? "R3 wrOk" : "R2 wrOk");
      idle(hi, (c >= 6) ? "R3 wrOk" : "R2 wrOk");
      if (hi < (1 << AW) - 1) idle(hi + 1, (c >= 6) ? "R3 wrOk" : "R2 wrOk");
    end
    prog(3'd0);
    idle(8'hC5, "R2 wrOk none");

    // R4 wpN low inhibits all
    for (int a = 0; a < 256; a += 37)
      step(1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, a, "R4 wrOk", "R7 protBits");

    // R6 cancel, then wrStart does nothing
    step(1'b0, 1'b1, 1'b1, 3'd5, 1'b0, 1'b0, 0, "R2 wrOk", "R5 protBits");
    step(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 0, "R4 wrOk", "R6 protBits");
    step(1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 0, "R2 wrOk", "R6 protBits");
    check(statAbort === 1'b0, "R6 abort one cycle", int'(statAbort), 0);

    // R8 commit and cancel in one cycle: cancel wins
    step(1'b0, 1'b1, 1'b1, 3'd7, 1'b0, 1'b0, 0, "R2 wrOk", "R5 protBits");
    step(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 0, "R4 wrOk", "R8 protBits");
    check(statAbort === 1'b1, "R8 abort", int'(statAbort), 1);
    check(protBits === 3'd0, "R8 unchanged", int'(protBits), 0);

    // R7 wpN low with csN high keeps pending; commit then immune
    step(1'b0, 1'b1, 1'b1, 3'd6, 1'b0, 1'b0, 0, "R2 wrOk", "R5 protBits");
    step(1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 0, "R4 wrOk", "R7 protBits");
    step(1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 0, "R4 wrOk", "R7 protBits");
    check(protBits === 3'd6, "R7 committed", int'(protBits), 6);
    step(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 0, "R4 wrOk", "R7 protBits");
    check(protBits === 3'd6, "R7 wp after commit", int'(protBits), 6);

    // R9 request ignored with wpN low or csN high
    step(1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 0, "R4 wrOk", "R9 protBits");
    step(1'b1, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 0, "R3 wrOk", "R9 protBits");
    step(1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 0, "R3 wrOk", "R9 protBits");
    check(protBits === 3'd6, "R9 unchanged", int'(protBits), 6);

    // R11 last captured code wins
    step(1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 0, "R3 wrOk", "R11 protBits");
    step(1'b0, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0, 0, "R3 wrOk", "R11 protBits");
    step(1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 0, "R3 wrOk", "R11 protBits");
    check(protBits === 3'd4, "R11 last wins", int'(protBits), 4);

    // R10 reject on protected and allowed starts
    idle(8'hD0, "R10 wrOk");
    check(wrReject === 1'b1, "R10 reject protected", int'(wrReject), 1);
    idle(8'h10, "R10 wrOk");
    check(wrReject === 1'b0, "R10 allowed", int'(wrReject), 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit rcs, rwp, rreq, rst, rmst;
      rcs  = ($urandom % 3) == 0;
      rwp  = ($urandom % 5) != 0;
      rreq = ($urandom % 3) == 0;
      rst  = ($urandom % 4) == 0;
      rmst = ($urandom % 2) == 0;
      step(rcs, rwp, rreq, 3'($urandom), rst, rmst, int'($urandom % 256),
           rwp ? "R2 wrOk" : "R4 wrOk", "R5 protBits");
    end

    finish_run();
  end

endmodule